// File: doc/BRIEF.md
# I3C Address Assignment Monitor

This block listens to the two wires of an I3C bus without ever driving them and follows each dynamic address assignment round. It resynchronises both lines to the system clock and finds START and STOP conditions. It decodes SDR framing well enough to spot the broadcast write header followed by the enter-assignment or reset-assignment command code. Inside a round it captures, for every target that claims arbitration, the 48-bit provisioned ID, the BCR and DCR bytes and the 7-bit address that the controller hands out. It then judges whether that address was taken.

Every finding leaves the block as one event on a single valid/data port. An event is a target record, the close of a round with its assignment count, a clear of the address table, or a bus-stuck fault. Flags on the event mark a zero ID, a failed address phase, an address already in the table, a round nobody answered, and a round that assigned fewer addresses than the configured expected count. Firmware or a debug buffer downstream logs these events and uses them to explain silent enumeration failures.

Top module: `daa_mon`

## Requirements
- R1: A round opens only on START, then header byte 8'hFC (address 7'h7E, write bit 0), then command byte 8'h07. Any other header or command byte produces no event, and the read headers and ID bits that follow are ignored.
- R2: After a START inside an open round, header 8'hFD with SDA low on its ninth bit starts a target slot. The next 64 bits, most significant first, are ID[47:0], then BCR[7:0], then DCR[7:0]. They are followed by 7 address bits, one parity bit and an acknowledge bit. The slot ends in one event of kind 0 (record) that carries ID, BCR, DCR and address on their ports.
- R3: A record whose ID is all zeros has flag bit 1 set. If its address phase succeeds, it still counts as assigned.
- R4: The address phase succeeds only when the 8 bits of address plus parity hold an odd number of ones and the ninth bit is low (ACK). Otherwise flag bit 0 is set and the round count does not advance. The event count field gives the round count after the slot.
- R5: Header 8'hFD answered with SDA high (NACK) closes the round with one event of kind 1 that carries the round count. Flag bit 3 (no responder) is set when that count is zero.
- R6: On a kind 1 event, flag bit 4 is set when the round count is below exp_cnt_i, and clear otherwise.
- R7: The command byte 8'h06 after the broadcast write header empties the table of assigned addresses and emits one event of kind 2. A successful record whose address is already in the table has flag bit 2 set.
- R8: When the synchronised SCL is high and SDA is low for stuck_cyc_i consecutive clocks, one event of kind 3 is raised and any open round is dropped. A shorter low period raises nothing, and a long one raises only one event until SDA returns high.
- R9: After reset, evt_valid_o stays low until bus activity creates an event. At most one event is presented per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| exp_cnt_i | input | CNT_W | Expected number of assignments per round |
| stuck_cyc_i | input | TMO_W | Stuck-low timeout in clocks, 0 disables |
| evt_valid_o | output | 1 | Event present this cycle |
| evt_kind_o | output | 2 | 0 record, 1 round end, 2 table clear, 3 stuck |
| evt_flags_o | output | 5 | bit0 address fail, bit1 zero ID, bit2 duplicate, bit3 no responder, bit4 short count |
| evt_pid_o | output | 48 | Captured provisioned ID |
| evt_bcr_o | output | 8 | Captured BCR |
| evt_dcr_o | output | 8 | Captured DCR |
| evt_addr_o | output | 7 | Address seen in the address phase |
| evt_count_o | output | CNT_W | Assignments in the current round |

## Verification
Two judgements can land on the same record event: the zero-ID check and the address-phase check. They are provoked together by driving an all-zero ID and then sending the address with its parity bit inverted. The bench expects both flag bits 0 and 1 on one event, a round count that does not move, and a closing count that leaves that slot out. A sweep over zero to three responders against expected counts of zero to three judges the no-responder and short-count flags arithmetically.

// File: rtl/daa_mon_pkg.sv
package daa_mon_pkg;
  localparam int ID_W   = 48;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int SLOT_W = ID_W + 2 * BYTE_W;
  localparam int FLAG_W = 5;

  localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;
  localparam logic [BYTE_W-1:0] CMD_ENTER  = 8'h07;
  localparam logic [BYTE_W-1:0] CMD_CLEAR  = 8'h06;

  localparam int F_ADDR_FAIL = 0;
  localparam int F_ZERO_ID   = 1;
  localparam int F_DUP       = 2;
  localparam int F_NO_RESP   = 3;
  localparam int F_SHORT     = 4;

  typedef enum logic [1:0] {
    EV_RECORD    = 2'd0,
    EV_ROUND_END = 2'd1,
    EV_TBL_CLR   = 2'd2,
    EV_STUCK     = 2'd3
  } evt_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CMD, ST_WAIT_SR, ST_SLOT_HDR, ST_ID, ST_ADDR
  } mon_st_e;
endpackage

// File: rtl/daa_line_sync.sv
module daa_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] scl_ff, sda_ff;
  logic         scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[MSB-1:0], scl_i};
      sda_ff <= {sda_ff[MSB-1:0], sda_i};
      scl_q  <= scl_ff[MSB];
      sda_q  <= sda_ff[MSB];
    end
  end

  assign scl_o      = scl_ff[MSB];
  assign sda_o      = sda_ff[MSB];
  assign scl_rise_o = scl_o & ~scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/daa_stuck_det.sv
module daa_stuck_det #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             stuck_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      stuck_o <= 1'b0;
    end else begin
      stuck_o <= 1'b0;
      if (!scl_i || sda_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q && tmo_i != '0) begin
        if (cnt_q == tmo_i - 1'b1) begin
          fired_q <= 1'b1;
          stuck_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  stuck_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_o |=> !stuck_o);
  // R8
  stuck_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stuck_o |-> ($past(scl_i) && !$past(sda_i)));
endmodule

// File: rtl/daa_round_fsm.sv
module daa_round_fsm
  import daa_mon_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic [CNT_W-1:0]  exp_cnt_i,
  output logic              evt_valid_o,
  output evt_kind_e         evt_kind_o,
  output logic [FLAG_W-1:0] evt_flags_o,
  output logic [ID_W-1:0]   evt_pid_o,
  output logic [BYTE_W-1:0] evt_bcr_o,
  output logic [BYTE_W-1:0] evt_dcr_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [CNT_W-1:0]  evt_count_o
);
  localparam int          TBL_N   = 1 << ADDR_W;
  localparam int          BIT_W   = $clog2(SLOT_W);
  localparam logic [BIT_W-1:0] LAST_BYTE = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_SLOT = BIT_W'(SLOT_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  mon_st_e            st_q;
  logic [BIT_W-1:0]   bit_q;
  logic [SLOT_W-1:0]  sh_q, sh_n, slot_q;
  logic               round_q;
  logic [CNT_W-1:0]   rcnt_q, rcnt_inc;
  logic [TBL_N-1:0]   tbl_q;
  logic [ADDR_W-1:0]  addr_w;
  logic               addr_fail, zero_id;
  logic [FLAG_W-1:0]  end_flags, rec_flags;

  assign sh_n      = {sh_q[SLOT_W-2:0], sda_i};
  assign addr_w    = sh_q[BYTE_W-1:1];
  assign addr_fail = !(^sh_q[BYTE_W-1:0]) || sda_i;
  assign zero_id   = slot_q[SLOT_W-1 -: ID_W] == '0;
  assign rcnt_inc  = (rcnt_q == CNT_MAX) ? rcnt_q : rcnt_q + 1'b1;

  always_comb begin
    end_flags            = '0;
    end_flags[F_NO_RESP] = rcnt_q == '0;
    end_flags[F_SHORT]   = rcnt_q < exp_cnt_i;
    rec_flags              = '0;
    rec_flags[F_ADDR_FAIL] = addr_fail;
    rec_flags[F_ZERO_ID]   = zero_id;
    rec_flags[F_DUP]       = !addr_fail && tbl_q[addr_w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      bit_q       <= '0;
      sh_q        <= '0;
      slot_q      <= '0;
      round_q     <= 1'b0;
      rcnt_q      <= '0;
      tbl_q       <= '0;
      evt_valid_o <= 1'b0;
      evt_kind_o  <= EV_RECORD;
      evt_flags_o <= '0;
      evt_pid_o   <= '0;
      evt_bcr_o   <= '0;
      evt_dcr_o   <= '0;
      evt_addr_o  <= '0;
      evt_count_o <= '0;
    end else begin
      evt_valid_o <= 1'b0;
      if (abort_i) begin
        st_q    <= ST_IDLE;
        round_q <= 1'b0;
      end else if (start_i) begin
        st_q  <= round_q ? ST_SLOT_HDR : ST_HDR;
        bit_q <= '0;
      end else if (stop_i) begin
        if (round_q) begin
          evt_valid_o <= 1'b1;
          evt_kind_o  <= EV_ROUND_END;
          evt_flags_o <= end_flags;
          evt_count_o <= rcnt_q;
        end
        round_q <= 1'b0;
        st_q    <= ST_IDLE;
      end else if (scl_rise_i) begin
        sh_q  <= sh_n;
        bit_q <= bit_q + 1'b1;
        unique case (st_q)
          ST_HDR: if (bit_q == LAST_BYTE) begin
            bit_q <= '0;
            st_q  <= (sh_q[BYTE_W-1:0] == {BCAST_ADDR, 1'b0}) ? ST_CMD : ST_IDLE;
          end
          ST_CMD: if (bit_q == LAST_BYTE) begin
            st_q <= ST_IDLE;
            if (sh_q[BYTE_W-1:0] == CMD_ENTER) begin
              round_q <= 1'b1;
              rcnt_q  <= '0;
              st_q    <= ST_WAIT_SR;
            end else if (sh_q[BYTE_W-1:0] == CMD_CLEAR) begin
              tbl_q       <= '0;
              evt_valid_o <= 1'b1;
              evt_kind_o  <= EV_TBL_CLR;
              evt_flags_o <= '0;
              evt_count_o <= '0;
            end
          end
          ST_SLOT_HDR: if (bit_q == LAST_BYTE) begin
            bit_q <= '0;
            if (sh_q[BYTE_W-1:0] == {BCAST_ADDR, 1'b1} && !sda_i) begin
              st_q <= ST_ID;
            end else begin
              evt_valid_o <= 1'b1;
              evt_kind_o  <= EV_ROUND_END;
              evt_flags_o <= end_flags;
              evt_count_o <= rcnt_q;
              round_q     <= 1'b0;
              st_q        <= ST_IDLE;
            end
          end
          ST_ID: if (bit_q == LAST_SLOT) begin
            slot_q <= sh_n;
            bit_q  <= '0;
            st_q   <= ST_ADDR;
          end
          ST_ADDR: if (bit_q == LAST_BYTE) begin
            evt_valid_o <= 1'b1;
            evt_kind_o  <= EV_RECORD;
            evt_flags_o <= rec_flags;
            evt_pid_o   <= slot_q[SLOT_W-1 -: ID_W];
            evt_bcr_o   <= slot_q[2*BYTE_W-1 -: BYTE_W];
            evt_dcr_o   <= slot_q[BYTE_W-1:0];
            evt_addr_o  <= addr_w;
            evt_count_o <= addr_fail ? rcnt_q : rcnt_inc;
            if (!addr_fail) begin
              rcnt_q        <= rcnt_inc;
              tbl_q[addr_w] <= 1'b1;
            end
            st_q <= ST_WAIT_SR;
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  rec_in_round_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EV_RECORD) |-> round_q);
  // R5
  round_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EV_ROUND_END) |-> !round_q);
  // R7
  tbl_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_kind_o == EV_TBL_CLR) |-> tbl_q == '0);
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (rcnt_q == $past(rcnt_q) || rcnt_q == $past(rcnt_q) + 1'b1 || rcnt_q == '0));
endmodule

// File: rtl/daa_mon.sv
module daa_mon
  import daa_mon_pkg::*;
#(
  parameter int  MAX_DEV     = 11,
  parameter int  TMO_W       = 16,
  parameter int  SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(MAX_DEV + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [CNT_W-1:0]  exp_cnt_i,
  input  logic [TMO_W-1:0]  stuck_cyc_i,
  output logic              evt_valid_o,
  output logic [1:0]        evt_kind_o,
  output logic [FLAG_W-1:0] evt_flags_o,
  output logic [ID_W-1:0]   evt_pid_o,
  output logic [BYTE_W-1:0] evt_bcr_o,
  output logic [BYTE_W-1:0] evt_dcr_o,
  output logic [ADDR_W-1:0] evt_addr_o,
  output logic [CNT_W-1:0]  evt_count_o
);
  logic scl_s, sda_s, scl_rise, start, stop, stuck;

  logic              f_valid;
  evt_kind_e         f_kind;
  logic [FLAG_W-1:0] f_flags;
  logic [ID_W-1:0]   f_pid;
  logic [BYTE_W-1:0] f_bcr, f_dcr;
  logic [ADDR_W-1:0] f_addr;
  logic [CNT_W-1:0]  f_count;

  daa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
    .start_o(start), .stop_o(stop)
  );

  daa_stuck_det #(.TMO_W(TMO_W)) u_stuck (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .tmo_i(stuck_cyc_i), .stuck_o(stuck)
  );

  daa_round_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise),
    .start_i(start), .stop_i(stop), .abort_i(stuck), .exp_cnt_i,
    .evt_valid_o(f_valid), .evt_kind_o(f_kind), .evt_flags_o(f_flags),
    .evt_pid_o(f_pid), .evt_bcr_o(f_bcr), .evt_dcr_o(f_dcr),
    .evt_addr_o(f_addr), .evt_count_o(f_count)
  );

  always_comb begin
    evt_valid_o = f_valid || stuck;
    evt_kind_o  = stuck ? EV_STUCK : f_kind;
    evt_flags_o = stuck ? '0 : f_flags;
    evt_pid_o   = f_pid;
    evt_bcr_o   = f_bcr;
    evt_dcr_o   = f_dcr;
    evt_addr_o  = f_addr;
    evt_count_o = stuck ? '0 : f_count;
  end

  // R9
  one_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stuck && f_valid));
endmodule

// File: tb/daa_mon_bench.sv
module daa_mon_bench;
  localparam int CNT_W = 4;
  localparam int TMO_W = 16;
  localparam int HB    = 4;
  localparam int EV_N  = 512;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
  logic [CNT_W-1:0] exp_cnt = '0;
  logic [TMO_W-1:0] tmo = 16'd40;
  logic             evt_valid;
  logic [1:0]       evt_kind;
  logic [4:0]       evt_flags;
  logic [47:0]      evt_pid;
  logic [7:0]       evt_bcr, evt_dcr;
  logic [6:0]       evt_addr;
  logic [CNT_W-1:0] evt_count;

  int n_chk = 0, n_err = 0, ev_n = 0;
  logic [1:0]       e_kind  [EV_N];
  logic [4:0]       e_flags [EV_N];
  logic [63:0]      e_slot  [EV_N];
  logic [6:0]       e_addr  [EV_N];
  logic [CNT_W-1:0] e_cnt   [EV_N];

  always #2 clk = ~clk;

  daa_mon u_daa_mon (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .exp_cnt_i(exp_cnt), .stuck_cyc_i(tmo),
    .evt_valid_o(evt_valid), .evt_kind_o(evt_kind), .evt_flags_o(evt_flags),
    .evt_pid_o(evt_pid), .evt_bcr_o(evt_bcr), .evt_dcr_o(evt_dcr),
    .evt_addr_o(evt_addr), .evt_count_o(evt_count)
  );

  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      if (ev_n < EV_N) begin
        e_kind[ev_n]  = evt_kind;
        e_flags[ev_n] = evt_flags;
        e_slot[ev_n]  = {evt_pid, evt_bcr, evt_dcr};
        e_addr[ev_n]  = evt_addr;
        e_cnt[ev_n]   = evt_count;
      end
      ev_n = ev_n + 1;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    sda = b; wclk(HB); scl = 1'b1; wclk(HB); scl = 1'b0;
  endtask

  task automatic do_start();
    if (!scl) begin
      sda = 1'b1; wclk(HB); scl = 1'b1; wclk(HB);
    end
    sda = 1'b0; wclk(HB); scl = 1'b0; wclk(HB);
  endtask

  task automatic do_stop();
    sda = 1'b0; wclk(HB); scl = 1'b1; wclk(HB); sda = 1'b1; wclk(2 * HB);
  endtask

  task automatic byte9(logic [7:0] b, logic ninth);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_out(ninth);
  endtask

  task automatic command(logic [7:0] hdr, logic [7:0] code);
    do_start();
    byte9(hdr, 1'b0);
    byte9(code, ~^code);
  endtask

  task automatic tbl_clear();
    command(8'hFC, 8'h06);
    do_stop();
  endtask

  task automatic target(logic [63:0] slot, logic [6:0] addr, logic bad_par, logic nack);
    do_start();
    byte9(8'hFD, 1'b0);
    for (int i = 63; i >= 0; i--) bit_out(slot[i]);
    byte9({addr, (~^addr) ^ bad_par}, nack);
  endtask

  task automatic end_round();
    do_start();
    byte9(8'hFD, 1'b1);
    do_stop();
  endtask

  function automatic logic [63:0] slot_of(int s);
    logic [47:0] id;
    id = {16'(s * 16'h1F3B + 16'h0101), 32'(s) * 32'h9E3779B1};
    return {id, 8'(s * 37 + 5), 8'(s * 11 + 200)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base;
    wclk(5);
    rst_n = 1'b1;
    wclk(20);
    // R9 reset state
    chk("R9 idle valid", evt_valid, 0);
    chk("R9 no events", ev_n, 0);

    // R1 wrong header and wrong command: no events at all
    base = ev_n;
    command(8'hFA, 8'h07);
    target(slot_of(1), 7'h30, 1'b0, 1'b0);
    end_round();
    chk("R1 bad header ignored", ev_n - base, 0);
    base = ev_n;
    command(8'hFC, 8'h05);
    target(slot_of(2), 7'h31, 1'b0, 1'b0);
    end_round();
    chk("R1 bad command ignored", ev_n - base, 0);
    base = ev_n;
    command(8'hFD, 8'h07);
    do_stop();
    chk("R1 read header ignored", ev_n - base, 0);

    // R2 R5 R6 sweep: responders x expected count
    for (int n = 0; n < 4; n++) begin
      for (int m = 0; m < 4; m++) begin
        exp_cnt = CNT_W'(m);
        base = ev_n;
        tbl_clear();
        command(8'hFC, 8'h07);
        for (int k = 0; k < n; k++) target(slot_of(n * 4 + k + 10), 7'(7'h10 + k), 1'b0, 1'b0);
        end_round();
        wclk(4);
        chk("R7 clear kind", e_kind[base], 2);
        chk("R5 event total", ev_n - base, n + 2);
        for (int k = 0; k < n; k++) begin
          chk("R2 kind", e_kind[base + 1 + k], 0);
          chk("R2 id bcr dcr", e_slot[base + 1 + k], slot_of(n * 4 + k + 10));
          chk("R2 addr", e_addr[base + 1 + k], 7'(7'h10 + k));
          chk("R2 flags", e_flags[base + 1 + k], 0);
          chk("R4 count", e_cnt[base + 1 + k], k + 1);
        end
        chk("R5 end kind", e_kind[base + 1 + n], 1);
        chk("R5 end count", e_cnt[base + 1 + n], n);
        chk("R6 end flags", e_flags[base + 1 + n],
            ((n == 0) ? 8 : 0) + ((n < m) ? 16 : 0));
      end
    end

    // R3 zero ID still assigned
    exp_cnt = 1;
    tbl_clear();
    base = ev_n;
    command(8'hFC, 8'h07);
    target({48'h0, 8'h11, 8'h22}, 7'h21, 1'b0, 1'b0);
    end_round();
    wclk(4);
    chk("R3 flags", e_flags[base], 5'b00010);
    chk("R3 count", e_cnt[base], 1);
    chk("R3 id", e_slot[base], {48'h0, 8'h11, 8'h22});
    chk("R5 end count after zero", e_cnt[base + 1], 1);

    // R4 parity error, NACK, then good slot
    exp_cnt = 3;
    base = ev_n;
    command(8'hFC, 8'h07);
    target(slot_of(50), 7'h22, 1'b1, 1'b0);
    target(slot_of(51), 7'h23, 1'b0, 1'b1);
    target(slot_of(52), 7'h24, 1'b0, 1'b0);
    end_round();
    wclk(4);
    chk("R4 parity flags", e_flags[base], 5'b00001);
    chk("R4 parity count", e_cnt[base], 0);
    chk("R4 nack flags", e_flags[base + 1], 5'b00001);
    chk("R4 nack count", e_cnt[base + 1], 0);
    chk("R4 good count", e_cnt[base + 2], 1);
    chk("R6 short flag", e_flags[base + 3], 5'b10000);
    chk("R6 end count", e_cnt[base + 3], 1);

    // R3 R4 zero ID and parity error on the same record
    exp_cnt = 0;
    base = ev_n;
    command(8'hFC, 8'h07);
    target({48'h0, 8'h01, 8'h02}, 7'h25, 1'b1, 1'b0);
    end_round();
    wclk(4);
    chk("R3 R4 both flags", e_flags[base], 5'b00011);
    chk("R4 both count", e_cnt[base], 0);
    chk("R5 both no resp", e_flags[base + 1], 5'b01000);

    // R7 duplicate address without clear, then clean after clear
    base = ev_n;
    command(8'hFC, 8'h07);
    target(slot_of(60), 7'h24, 1'b0, 1'b0);
    end_round();
    wclk(4);
    chk("R7 dup flag", e_flags[base], 5'b00100);
    base = ev_n;
    tbl_clear();
    wclk(4);
    chk("R7 clear event", e_kind[base], 2);
    command(8'hFC, 8'h07);
    target(slot_of(61), 7'h24, 1'b0, 1'b0);
    end_round();
    wclk(4);
    chk("R7 clean after clear", e_flags[base + 1], 0);
    chk("R7 slot kind", e_kind[base + 1], 0);

    // R8 short low: nothing; long low: exactly one stuck event
    base = ev_n;
    sda = 1'b0; wclk(30); sda = 1'b1; wclk(10);
    chk("R8 short low", ev_n - base, 0);
    base = ev_n;
    sda = 1'b0; wclk(150); sda = 1'b1; wclk(10);
    chk("R8 one stuck event", ev_n - base, 1);
    chk("R8 stuck kind", e_kind[base], 3);

    // R9 nothing after bus returns idle
    base = ev_n;
    wclk(50);
    chk("R9 quiet idle", ev_n - base, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule